// File: doc/BRIEF.md
# Word-to-Byte Bus Width Adapter

This block connects a 16-bit processor-side bus to a peripheral that has only eight data lines. A single-byte request is steered onto the half of the 16-bit data path that its address calls for. A full 16-bit request that starts on an even address is broken into two consecutive byte cycles on the narrow bus. The processor is kept stalled until the second byte is done.

The device never sees the processor's low address bit or its high-byte enable directly. Both are rebuilt inside the block for each byte cycle. A DMA requester can also issue accesses through the same narrow port. Its accesses are always single bytes, and it is given priority when both masters ask in the same idle cycle.

Each byte cycle on the narrow side lasts a fixed number of clocks, set by a parameter. During all but the final clock, one active-low strobe is asserted.

Top module: `bus_sizer`

## Requirements
- R1: After reset both device strobes are high (inactive), `cpu_done`, `dma_done` and `cpu_wait` are low, and `rd_data` is zero.
- R2: A processor byte access with `cpu_addr[0]`=0 and `cpu_hi_en`=0 uses one byte cycle with device bit 0 low and `dev_hi_en` low. A write drives `cpu_wdata[7:0]`. A read returns the device byte in `rd_data[7:0]`, with `rd_data[15:8]`=0.
- R3: A processor access with `cpu_addr[0]`=1 is one byte cycle with device bit 0 high and `dev_hi_en` high. A write drives `cpu_wdata[15:8]`. A read returns the byte in `rd_data[15:8]`, with `rd_data[7:0]`=0.
- R4: A processor write with `cpu_addr[0]`=0 and `cpu_hi_en`=1 makes two byte cycles. The first goes to the even device address with `cpu_wdata[7:0]`. The second goes to the odd address with `cpu_wdata[15:8]`.
- R5: A processor word read (same encoding as R4) reads the even byte and then the odd byte. Both are presented together on `rd_data` as {odd, even} in the cycle where `cpu_done` pulses.
- R6: While `cpu_req` is high, `cpu_wait` stays high until the single cycle in which `cpu_done` pulses. `cpu_done` never lasts two cycles.
- R7: A DMA access is always one byte cycle. Its lane is chosen by `dma_addr[0]` (0 = `dma_wdata[7:0]` / `rd_data[7:0]`, 1 = upper lane, with `dev_hi_en` following the lane). It ends with `dma_done` and never with `cpu_done`, and it raises no `cpu_wait` when `cpu_req` is low.
- R8: When both masters request in the same idle cycle, the DMA access finishes first. The processor is held in wait during it and is served afterwards.
- R9: Every byte cycle lasts CYC_CLKS clocks, with its strobe low for the first CYC_CLKS-1 of them. Read and write strobes are never low together. The device address is stable while a strobe is low. Exactly one strobe pulse is made per byte cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_hi_en | input | 1 | Processor high-byte enable, active high |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_wait | output | 1 | Stall to the processor |
| cpu_done | output | 1 | One-cycle completion of a processor access |
| dma_req | input | 1 | DMA request, held until `dma_done` |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | ADDR_W | DMA byte address |
| dma_wdata | input | 16 | DMA write data, byte taken from the addressed lane |
| dma_done | output | 1 | One-cycle completion of a DMA access |
| rd_data | output | 16 | Read result, valid with either done |
| dev_addr | output | ADDR_W | Device address with regenerated bit 0 |
| dev_hi_en | output | 1 | Regenerated high-byte enable for the device |
| dev_rd_n | output | 1 | Device read strobe, active low |
| dev_wr_n | output | 1 | Device write strobe, active low |
| dev_wdata | output | 8 | Byte driven to the device |
| dev_rdata | input | 8 | Byte returned by the device |

## Verification
A processor word request and a DMA byte request can arrive in the same idle cycle. The bench provokes this by raising both requests on the same clock edge. It then records the cycles at which `dma_done` and `cpu_done` pulse. The result is judged correct if the DMA completion comes strictly first with the correct byte, `cpu_wait` stays high through it, and the later processor result holds both word halves taken from the byte-addressed memory model.

// File: rtl/bus_sizer.sv
module bus_sizer #(
  parameter int ADDR_W   = 20,
  parameter int CYC_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_hi_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  output logic              cpu_wait,
  output logic              cpu_done,
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [15:0]       dma_wdata,
  output logic              dma_done,
  output logic [15:0]       rd_data,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dev_hi_en,
  output logic              dev_rd_n,
  output logic              dev_wr_n,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata
);

  localparam int CW = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 1;
  localparam logic [CW-1:0] LAST   = CW'(CYC_CLKS - 1);
  localparam logic [CW-1:0] SAMPLE = CW'(CYC_CLKS - 2);

  logic              busy, by_dma, wr, split, lane;
  logic [ADDR_W-1:1] a_hi;
  logic [15:0]       wbuf;
  logic [CW-1:0]     cnt;
  logic [7:0]        lat_lo, lat_hi;

  logic              take;
  logic [ADDR_W-1:0] sel_addr;
  logic              strobe_on;

  assign take     = !busy && !cpu_done && !dma_done && (cpu_req || dma_req);
  assign sel_addr = dma_req ? dma_addr : cpu_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; by_dma <= 1'b0; wr <= 1'b0; split <= 1'b0; lane <= 1'b0;
      a_hi <= '0; wbuf <= '0; cnt <= '0; lat_lo <= '0; lat_hi <= '0;
      cpu_done <= 1'b0; dma_done <= 1'b0;
    end else begin
      cpu_done <= 1'b0;
      dma_done <= 1'b0;
      if (take) begin
        busy   <= 1'b1;
        by_dma <= dma_req;
        wr     <= dma_req ? dma_we : cpu_we;
        split  <= !dma_req && cpu_hi_en && !cpu_addr[0];
        lane   <= sel_addr[0];
        a_hi   <= sel_addr[ADDR_W-1:1];
        wbuf   <= dma_req ? dma_wdata : cpu_wdata;
        cnt    <= '0;
        lat_lo <= '0;
        lat_hi <= '0;
      end else if (busy) begin
        if (cnt == SAMPLE && !wr) begin
          if (lane) lat_hi <= dev_rdata;
          else      lat_lo <= dev_rdata;
        end
        if (cnt == LAST) begin
          cnt <= '0;
          if (split && !lane) begin
            lane <= 1'b1;
          end else begin
            busy     <= 1'b0;
            cpu_done <= !by_dma;
            dma_done <= by_dma;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign strobe_on = busy && (cnt != LAST);
  assign dev_addr  = {a_hi, lane};
  assign dev_hi_en = busy && lane;
  assign dev_rd_n  = !(strobe_on && !wr);
  assign dev_wr_n  = !(strobe_on && wr);
  assign dev_wdata = lane ? wbuf[15:8] : wbuf[7:0];
  assign rd_data   = {lat_hi, lat_lo};
  assign cpu_wait  = cpu_req && !cpu_done;

  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_rd_n && !dev_wr_n));

  a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((!dev_rd_n && $past(!dev_rd_n)) || (!dev_wr_n && $past(!dev_wr_n))) |-> $stable(dev_addr));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  a_r7_dma_not_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> !cpu_done);

  a_r9_done_after_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done || dma_done) |-> $past(dev_rd_n && dev_wr_n));

  a_r4_second_lane_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dev_wr_n) && $past(busy) && !$past(cpu_done) && !$past(dma_done)) |-> dev_addr[0]);

endmodule

// File: tb/bus_sizer_bench.sv
`timescale 1ns/1ps
module bus_sizer_bench;
  localparam int AW  = 20;
  localparam int CYC = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic cpu_req, cpu_we, cpu_hi_en, dma_req, dma_we;
  logic [AW-1:0] cpu_addr, dma_addr;
  logic [15:0] cpu_wdata, dma_wdata;
  logic cpu_wait, cpu_done, dma_done;
  logic [15:0] rd_data;
  logic [AW-1:0] dev_addr;
  logic dev_hi_en, dev_rd_n, dev_wr_n;
  logic [7:0] dev_wdata, dev_rdata;

  bus_sizer #(.ADDR_W(AW), .CYC_CLKS(CYC)) u_bus_sizer (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_hi_en(cpu_hi_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wait(cpu_wait), .cpu_done(cpu_done),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_done(dma_done), .rd_data(rd_data),
    .dev_addr(dev_addr), .dev_hi_en(dev_hi_en), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata));

  logic [7:0] dev_mem [256];
  logic [7:0] ref_mem [256];
  assign dev_rdata = dev_rd_n ? 8'h00 : dev_mem[dev_addr[7:0]];

  int   total = 0;
  int   bad   = 0;
  logic rd_p = 1'b1, wr_p = 1'b1;
  int   pulse_cnt = 0;
  int   run = 0, last_width = 0;
  logic both_low = 1'b0;
  logic       lane_log [64];
  logic       hien_log [64];
  logic [7:0] wd_log   [64];

  always @(posedge clk) begin
    rd_p <= dev_rd_n;
    wr_p <= dev_wr_n;
    if ((!dev_rd_n && rd_p) || (!dev_wr_n && wr_p)) begin
      lane_log[pulse_cnt % 64] <= dev_addr[0];
      hien_log[pulse_cnt % 64] <= dev_hi_en;
      wd_log[pulse_cnt % 64]   <= dev_wdata;
      pulse_cnt <= pulse_cnt + 1;
    end
    if (!dev_rd_n || !dev_wr_n) run <= run + 1;
    else if (run != 0) begin last_width <= run; run <= 0; end
    if (!dev_rd_n && !dev_wr_n) both_low <= 1'b1;
    if (!dev_wr_n) dev_mem[dev_addr[7:0]] <= dev_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // dma, we, hi_en, addr[7:0], wdata, expected pulses
  localparam int NV = 14;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 8'h10, 16'hBEEF, 2'd2},
    {1'b0, 1'b1, 1'b0, 8'h20, 16'hAA33, 2'd1},
    {1'b0, 1'b1, 1'b1, 8'h21, 16'h4499, 2'd1},
    {1'b1, 1'b1, 1'b0, 8'h30, 16'h7755, 2'd1},
    {1'b1, 1'b1, 1'b0, 8'h31, 16'h6688, 2'd1},
    {1'b0, 1'b0, 1'b1, 8'h10, 16'h0000, 2'd2},
    {1'b0, 1'b0, 1'b1, 8'h20, 16'h0000, 2'd2},
    {1'b0, 1'b0, 1'b0, 8'h30, 16'h0000, 2'd1},
    {1'b0, 1'b0, 1'b1, 8'h31, 16'h0000, 2'd1},
    {1'b1, 1'b0, 1'b0, 8'h20, 16'h0000, 2'd1},
    {1'b1, 1'b0, 1'b0, 8'h11, 16'h0000, 2'd1},
    {1'b0, 1'b0, 1'b1, 8'h40, 16'h0000, 2'd2},
    {1'b0, 1'b1, 1'b1, 8'h40, 16'h1234, 2'd2},
    {1'b0, 1'b0, 1'b1, 8'h40, 16'h0000, 2'd2}
  };

  function automatic logic [15:0] exp_read(input logic d, input logic h, input logic [7:0] a);
    if (a[0])           return {ref_mem[a], 8'h00};
    else if (!d && h)   return {ref_mem[a | 8'h01], ref_mem[a]};
    else                return {8'h00, ref_mem[a]};
  endfunction

  task automatic access(input logic [28:0] v);
    logic d, w, h; logic [7:0] a; logic [15:0] wd; int ep;
    logic word; string tag; int p0, n, dn; logic wait_ok, other; logic [15:0] got;
    {d, w, h, a, wd} = v[28:2];
    ep   = int'(v[1:0]);
    word = !d && h && !a[0];
    tag  = d ? "R7" : word ? (w ? "R4" : "R5") : (a[0] ? "R3" : "R2");
    p0 = pulse_cnt;
    @(negedge clk);
    if (d) begin dma_req = 1; dma_we = w; dma_addr = AW'(a); dma_wdata = wd; end
    else begin cpu_req = 1; cpu_we = w; cpu_hi_en = h; cpu_addr = AW'(a); cpu_wdata = wd; end
    n = 0; dn = 0; wait_ok = 1; other = 0;
    while (dn == 0 && n < 100) begin
      @(negedge clk); n++;
      if (d) begin
        if (dma_done) dn = 1;
        if (cpu_wait) wait_ok = 0;
        if (cpu_done) other = 1;
      end else begin
        if (cpu_done) dn = 1; else if (!cpu_wait) wait_ok = 0;
        if (dma_done) other = 1;
      end
    end
    got = rd_data;
    if (d) dma_req = 0; else cpu_req = 0;
    chk({tag, " done"}, 32'(dn), 32'd1);
    chk("R6 wait/no-stray-done", {30'd0, wait_ok, other}, 32'h2);
    chk("R9 pulses", 32'(pulse_cnt - p0), 32'(ep));
    chk("R9 strobe width", 32'(last_width), 32'(CYC - 1));
    chk({tag, " first lane"}, 32'(lane_log[p0 % 64]), 32'(a[0]));
    chk({tag, " last lane"}, 32'(lane_log[(pulse_cnt - 1) % 64]), word ? 32'd1 : 32'(a[0]));
    chk("R3 hi_en regen", 32'(hien_log[(pulse_cnt - 1) % 64]), 32'(lane_log[(pulse_cnt - 1) % 64]));
    if (w) begin
      if (word) begin
        ref_mem[a] = wd[7:0]; ref_mem[a | 8'h01] = wd[15:8];
        chk("R4 low byte first", 32'(wd_log[p0 % 64]), 32'(wd[7:0]));
        chk("R4 high byte second", 32'(wd_log[(p0 + 1) % 64]), 32'(wd[15:8]));
        chk("R4 mem pair", {16'd0, dev_mem[a | 8'h01], dev_mem[a]}, {16'd0, wd});
      end else begin
        ref_mem[a] = a[0] ? wd[15:8] : wd[7:0];
        chk({tag, " mem byte"}, 32'(dev_mem[a]), 32'(ref_mem[a]));
      end
    end else begin
      chk({tag, " read data"}, 32'(got), 32'(exp_read(d, h, a)));
    end
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dd, cd, n; logic w_ok; logic [15:0] dma_got, cpu_got;
    for (int i = 0; i < 256; i++) begin
      dev_mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_hi_en = 0; cpu_addr = '0; cpu_wdata = '0;
    dma_req = 0; dma_we = 0; dma_addr = '0; dma_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 strobes", {30'd0, dev_rd_n, dev_wr_n}, 32'h3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done/wait", {29'd0, cpu_done, dma_done, cpu_wait}, 32'h0);
    chk("R1 rd_data", 32'(rd_data), 32'h0);

    for (int k = 0; k < NV; k++) access(VEC[k]);

    // R8: both masters raise requests on the same edge
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_hi_en = 1; cpu_addr = AW'(8'h40);
    dma_req = 1; dma_we = 0; dma_addr = AW'(8'h21);
    dd = 0; cd = 0; n = 0; w_ok = 1; dma_got = '0; cpu_got = '0;
    while (cd == 0 && n < 200) begin
      @(negedge clk); n++;
      if (cd == 0 && dd == 0 && !cpu_wait) w_ok = 0;
      if (dma_done && dd == 0) begin dd = n; dma_got = rd_data; dma_req = 0; end
      if (cpu_done) begin cd = n; cpu_got = rd_data; cpu_req = 0; end
    end
    chk("R8 dma finishes first", 32'(dd > 0 && cd > dd), 32'd1);
    chk("R8 cpu held during dma", 32'(w_ok), 32'd1);
    chk("R8 dma byte", 32'(dma_got), 32'(exp_read(1'b1, 1'b0, 8'h21)));
    chk("R8 cpu word", 32'(cpu_got), 32'(exp_read(1'b0, 1'b1, 8'h40)));
    repeat (4) @(negedge clk);
    chk("R9 strobes never both low", 32'(both_low), 32'd0);
    chk("R9 idle strobes", {30'd0, dev_rd_n, dev_wr_n}, 32'h3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule